// File: doc/BRIEF.md
# DMA Channel Control Sequencer

This block is the control state machine of one channel in a multi-channel DMA engine. Software programs a control word holding an enable bit, a quiet-interrupt bit and a 4-bit chain target. It starts the channel either through a control write flagged as a trigger, through a write to a separate trigger register, or through a chain pulse from another channel. At start the block loads the transfer count. It then grants transfers to the datapath, counting down one for each completion strobe. When the count runs out it drops BUSY and reports completion.

On completion the channel may send a one-cycle trigger to another channel. It may also set a sticky interrupt bit. In quiet mode the interrupt is held back until software writes zero to the trigger register, which marks the end of a list of control blocks. Clearing the enable bit pauses a running sequence without losing its place. Read and write bus errors from the datapath are kept as sticky flags until software clears them.

Top module: `dma_chan_ctrl`

## Requirements
- R1: When the enable bit (control bit 0) is 1 and the channel is idle, any of three events starts the channel: a control write with `ctrl_trig` high, a nonzero write to the trigger register, or a `chain_in` pulse. A start with a nonzero count raises `busy` on the next cycle, and `xfer_req` is high while the channel is busy and enabled.
- R2: When enable is 0 (taking the value written in the same cycle, if there is one), all three kinds of trigger are ignored and `busy` stays low.
- R3: Clearing enable while busy drops `xfer_req` on the next cycle and keeps `busy` high. Setting enable again raises `xfer_req` and the countdown resumes where it stopped.
- R4: At start, `count_in` is loaded. Each `xfer_done` while busy takes one from the count. `busy` falls in the cycle after the `xfer_done` that uses up the count. Triggers that arrive while busy are ignored.
- R5: A start with `count_in` equal to zero completes at once: `busy` never rises, and the completion effects appear in the next cycle.
- R6: A completion pulses `chain_out` for one cycle in the next cycle, and `chain_dst` shows the chain field (control bits 5:2). There is no pulse when that field equals the parameter `CHAN_ID`.
- R7: After reset, `busy`, `xfer_req`, `chain_out`, `irq`, `rd_err` and `wr_err` are 0, and `chain_dst` equals `CHAN_ID`.
- R8: With quiet mode (control bit 1) at 0, every completion sets `irq`.
- R9: With quiet mode at 1, completion does not set `irq`. A write of zero to the trigger register sets `irq` instead.
- R10: A zero write to the trigger register never starts the channel. With quiet mode at 0 it leaves `irq` unchanged.
- R11: `rd_err` and `wr_err` latch `rd_err_in` and `wr_err_in`. They clear only on a control write with bit 6 (read) or bit 7 (write) set. A new error in the same cycle as the clear takes precedence.
- R12: `irq` stays set until a control write with bit 8 set clears it. A new interrupt event in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_trig | input | 1 | Marks the control write as a trigger |
| ctrl_wdata | input | 32 | Control write data |
| trig_we | input | 1 | Trigger register write strobe |
| trig_wdata | input | 32 | Trigger register write data; zero is a null write |
| chain_in | input | 1 | Chain trigger from another channel |
| count_in | input | CNT_W | Transfer count loaded at start |
| xfer_done | input | 1 | One transfer finished in the datapath |
| rd_err_in | input | 1 | Read bus error from the datapath |
| wr_err_in | input | 1 | Write bus error from the datapath |
| busy | output | 1 | Channel has a sequence in progress |
| xfer_req | output | 1 | Datapath may issue transfers |
| chain_out | output | 1 | One-cycle chain trigger |
| chain_dst | output | 4 | Channel targeted by the chain trigger |
| irq | output | 1 | Sticky interrupt request |
| rd_err | output | 1 | Sticky read error flag |
| wr_err | output | 1 | Sticky write error flag |

## Verification
The channel is started by each of its three trigger paths, so a start that works through one path but not another is exposed. Countdowns are run both with no break and with a pause in the middle, so resuming from the held count can be told apart from restarting. Completion is driven with a foreign chain target, a self target, a zero count, and quiet mode on and off. This separates chain pulses from interrupts and separates null writes from real triggers. Clears that arrive together with a new event show which one takes precedence.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    localparam int DATA_W     = 32;
    localparam int CHAIN_W    = 4;
    localparam int EN_BIT     = 0;
    localparam int QUIET_BIT  = 1;
    localparam int CHAIN_LSB  = 2;
    localparam int RDCLR_BIT  = 6;
    localparam int WRCLR_BIT  = 7;
    localparam int IRQCLR_BIT = 8;
    localparam int FLAG_N     = 3;
    localparam int F_IRQ      = 0;
    localparam int F_RD       = 1;
    localparam int F_WR       = 2;

    typedef struct packed {
        logic               en;
        logic               quiet;
        logic [CHAIN_W-1:0] chain;
    } cfg_t;
endpackage

// File: rtl/dma_trig_decode.sv
module dma_trig_decode
    import dma_chan_pkg::*;
(
    input  logic              ctrl_we,
    input  logic              ctrl_trig,
    input  logic              trig_we,
    input  logic [DATA_W-1:0] trig_wdata,
    input  logic              chain_in,
    input  logic              en_eff,
    input  logic              busy,
    output logic              start,
    output logic              null_wr
);
    logic any_trig;

    always_comb begin
        null_wr  = trig_we && (trig_wdata == '0);
        any_trig = (ctrl_we && ctrl_trig) || (trig_we && !null_wr) || chain_in;
        start    = any_trig && en_eff && !busy;
    end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count_in,
    input  logic             xfer_done,
    input  logic             en,
    output logic             busy,
    output logic             xfer_req,
    output logic             complete
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] rem;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        complete = 1'b0;
        if (s_q.busy && xfer_done) begin
            s_d.rem = s_q.rem - CNT_W'(1);
            if (s_q.rem == CNT_W'(1)) begin
                s_d.busy = 1'b0;
                complete = 1'b1;
            end
        end
        if (start) begin
            if (count_in == '0) begin
                complete = 1'b1;
            end else begin
                s_d.busy = 1'b1;
                s_d.rem  = count_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = s_q.busy;
    assign xfer_req = s_q.busy & en;
endmodule

// File: rtl/dma_sticky_flags.sv
module dma_sticky_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    logic [N-1:0] flag_d, flag_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb flag_d[i] = set[i] | (flag_q[i] & ~clr[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int CHAN_ID = 8,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic               ctrl_trig,
    input  logic [DATA_W-1:0]  ctrl_wdata,
    input  logic               trig_we,
    input  logic [DATA_W-1:0]  trig_wdata,
    input  logic               chain_in,
    input  logic [CNT_W-1:0]   count_in,
    input  logic               xfer_done,
    input  logic               rd_err_in,
    input  logic               wr_err_in,
    output logic               busy,
    output logic               xfer_req,
    output logic               chain_out,
    output logic [CHAIN_W-1:0] chain_dst,
    output logic               irq,
    output logic               rd_err,
    output logic               wr_err
);
    localparam logic [CHAIN_W-1:0] SELF_ID = CHAIN_W'(CHAN_ID);

    typedef struct packed {
        cfg_t cfg;
        logic chain_pulse;
    } top_t;

    top_t r_d, r_q;
    logic start_w, null_w, complete_w;
    logic [FLAG_N-1:0] flag_set, flag_clr, flag_q;

    dma_trig_decode u_trig (
        .ctrl_we    (ctrl_we),
        .ctrl_trig  (ctrl_trig),
        .trig_we    (trig_we),
        .trig_wdata (trig_wdata),
        .chain_in   (chain_in),
        .en_eff     (r_d.cfg.en),
        .busy       (busy),
        .start      (start_w),
        .null_wr    (null_w)
    );

    dma_xfer_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .count_in  (count_in),
        .xfer_done (xfer_done),
        .en        (r_q.cfg.en),
        .busy      (busy),
        .xfer_req  (xfer_req),
        .complete  (complete_w)
    );

    always_comb begin
        r_d = r_q;
        if (ctrl_we) begin
            r_d.cfg.en    = ctrl_wdata[EN_BIT];
            r_d.cfg.quiet = ctrl_wdata[QUIET_BIT];
            r_d.cfg.chain = ctrl_wdata[CHAIN_LSB +: CHAIN_W];
        end
        r_d.chain_pulse = complete_w && (r_d.cfg.chain != SELF_ID);

        flag_set        = '0;
        flag_clr        = '0;
        flag_set[F_IRQ] = (complete_w && !r_d.cfg.quiet) || (null_w && r_d.cfg.quiet);
        flag_set[F_RD]  = rd_err_in;
        flag_set[F_WR]  = wr_err_in;
        flag_clr[F_IRQ] = ctrl_we && ctrl_wdata[IRQCLR_BIT];
        flag_clr[F_RD]  = ctrl_we && ctrl_wdata[RDCLR_BIT];
        flag_clr[F_WR]  = ctrl_we && ctrl_wdata[WRCLR_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cfg.en      <= 1'b0;
            r_q.cfg.quiet   <= 1'b0;
            r_q.cfg.chain   <= SELF_ID;
            r_q.chain_pulse <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    dma_sticky_flags #(.N(FLAG_N)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .flag  (flag_q)
    );

    assign chain_out = r_q.chain_pulse;
    assign chain_dst = r_q.cfg.chain;
    assign irq       = flag_q[F_IRQ];
    assign rd_err    = flag_q[F_RD];
    assign wr_err    = flag_q[F_WR];
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk
    import dma_chan_pkg::*;
#(
    parameter int CHAN_ID = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctrl_we,
    input logic [DATA_W-1:0]  ctrl_wdata,
    input logic               ctrl_trig,
    input logic               trig_we,
    input logic [DATA_W-1:0]  trig_wdata,
    input logic               chain_in,
    input logic               xfer_done,
    input logic               start_w,
    input logic               busy,
    input logic               xfer_req,
    input logic               chain_out,
    input logic [CHAIN_W-1:0] chain_dst,
    input logic               irq,
    input logic               rd_err,
    input logic               wr_err
);
    assert_req_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> busy);

    assert_busy_rise_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_w));

    assert_busy_fall_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(xfer_done));

    assert_chain_not_self_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chain_out |-> (chain_dst != CHAIN_W'(CHAN_ID)));

    assert_null_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_we && trig_wdata == '0 && !(ctrl_we && ctrl_trig) && !chain_in && !busy)
        |=> !busy);

    assert_irq_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(ctrl_we && ctrl_wdata[IRQCLR_BIT]));

    assert_rderr_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_err) |-> $past(ctrl_we && ctrl_wdata[RDCLR_BIT]));

    assert_wrerr_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_err) |-> $past(ctrl_we && ctrl_wdata[WRCLR_BIT]));
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.CHAN_ID(CHAN_ID)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_trig  (ctrl_trig),
    .trig_we    (trig_we),
    .trig_wdata (trig_wdata),
    .chain_in   (chain_in),
    .xfer_done  (xfer_done),
    .start_w    (start_w),
    .busy       (busy),
    .xfer_req   (xfer_req),
    .chain_out  (chain_out),
    .chain_dst  (chain_dst),
    .irq        (irq),
    .rd_err     (rd_err),
    .wr_err     (wr_err)
);

// File: tb/tb_dma_chan_ctrl.sv
module tb_dma_chan_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ID    = 8;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_we = 0, ctrl_trig = 0, trig_we = 0, chain_in = 0;
    logic xfer_done = 0, rd_err_in = 0, wr_err_in = 0;
    logic [31:0] ctrl_wdata = '0, trig_wdata = '0;
    logic [CNT_W-1:0] count_in = '0;
    logic busy, xfer_req, chain_out, irq, rd_err, wr_err;
    logic [3:0] chain_dst;

    int vectors = 0;
    int misses  = 0;
    string cur_req = "R7";

    bit m_en, m_quiet, m_busy, m_irq, m_rd, m_wr, m_cout;
    int m_chain, m_rem;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_ctrl #(.CHAN_ID(ID), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_trig(ctrl_trig),
        .ctrl_wdata(ctrl_wdata), .trig_we(trig_we), .trig_wdata(trig_wdata),
        .chain_in(chain_in), .count_in(count_in), .xfer_done(xfer_done),
        .rd_err_in(rd_err_in), .wr_err_in(wr_err_in), .busy(busy),
        .xfer_req(xfer_req), .chain_out(chain_out), .chain_dst(chain_dst),
        .irq(irq), .rd_err(rd_err), .wr_err(wr_err)
    );

    task automatic model_step();
        bit en_n, quiet_n, trig, done, nullw, clr;
        int chain_n;
        en_n    = ctrl_we ? ctrl_wdata[0] : m_en;
        quiet_n = ctrl_we ? ctrl_wdata[1] : m_quiet;
        chain_n = ctrl_we ? int'(ctrl_wdata[5:2]) : m_chain;
        nullw   = trig_we && (trig_wdata == 0);
        trig    = en_n && !m_busy &&
                  ((ctrl_we && ctrl_trig) || (trig_we && !nullw) || chain_in);
        done = 0;
        if (m_busy && xfer_done) begin
            if (m_rem == 1) begin done = 1; m_busy = 0; end
            m_rem = m_rem - 1;
        end
        if (trig) begin
            if (count_in == 0) done = 1;
            else begin m_busy = 1; m_rem = int'(count_in); end
        end
        m_cout = done && (chain_n != ID);
        clr = ctrl_we && ctrl_wdata[8];
        if ((done && !quiet_n) || (nullw && quiet_n)) m_irq = 1;
        else if (clr) m_irq = 0;
        if (rd_err_in) m_rd = 1; else if (ctrl_we && ctrl_wdata[6]) m_rd = 0;
        if (wr_err_in) m_wr = 1; else if (ctrl_we && ctrl_wdata[7]) m_wr = 0;
        m_en = en_n; m_quiet = quiet_n; m_chain = chain_n;
    endtask

    task automatic compare();
        vectors++;
        if (busy !== m_busy || xfer_req !== (m_busy && m_en) || chain_out !== m_cout ||
            chain_dst !== 4'(m_chain) || irq !== m_irq || rd_err !== m_rd || wr_err !== m_wr) begin
            misses++;
            $display("FAIL %s model: actual b%0b q%0b c%0b d%0d i%0b r%0b w%0b expected b%0b q%0b c%0b d%0d i%0b r%0b w%0b",
                cur_req, busy, xfer_req, chain_out, chain_dst, irq, rd_err, wr_err,
                m_busy, m_busy && m_en, m_cout, m_chain, m_irq, m_rd, m_wr);
        end
    endtask

    task automatic chk(int act, int exp, string tag);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        compare();
        ctrl_we = 0; ctrl_trig = 0; trig_we = 0; chain_in = 0;
        xfer_done = 0; rd_err_in = 0; wr_err_in = 0;
    endtask

    task automatic wctrl(logic [31:0] v, bit t);
        ctrl_we = 1; ctrl_wdata = v; ctrl_trig = t;
        cyc();
    endtask

    task automatic wtrig(logic [31:0] v);
        trig_we = 1; trig_wdata = v;
        cyc();
    endtask

    task automatic done_n(int n);
        for (int i = 0; i < n; i++) begin xfer_done = 1; cyc(); end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        misses++;
        $display("FAIL R4 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        m_chain = ID; m_rem = 0;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        // R7 reset state
        chk(busy, 0, "R7 busy"); chk(irq, 0, "R7 irq");
        chk(int'(chain_dst), ID, "R7 chain_dst");
        chk(rd_err | wr_err | chain_out | xfer_req, 0, "R7 flags");
        rst_n = 1;
        cyc();

        // R1 start through trigger register
        cur_req = "R1";
        wctrl(32'h0000_000D, 0);          // en=1, chain=3
        count_in = 3;
        wtrig(32'h0000_1000);
        chk(busy, 1, "R1 busy"); chk(xfer_req, 1, "R1 xfer_req");

        // R4 retrigger ignored, countdown
        cur_req = "R4";
        count_in = 9;
        wtrig(32'h0000_2000);
        done_n(2);
        chk(busy, 1, "R4 busy mid");
        done_n(1);
        chk(busy, 0, "R4 busy end");
        chk(chain_out, 1, "R6 chain pulse");
        chk(int'(chain_dst), 3, "R6 chain_dst");
        chk(irq, 1, "R8 irq on completion");
        cyc();
        chk(chain_out, 0, "R6 pulse one cycle");

        // R12 irq acknowledge
        cur_req = "R12";
        wctrl(32'h0000_010D, 0);
        chk(irq, 0, "R12 irq cleared");

        // R3 pause and resume
        cur_req = "R3";
        count_in = 4;
        wctrl(32'h0000_000D, 1);
        chk(busy, 1, "R1 ctrl trigger start");
        done_n(1);
        wctrl(32'h0000_000C, 0);
        chk(xfer_req, 0, "R3 paused req"); chk(busy, 1, "R3 paused busy");
        repeat (3) cyc();
        chk(busy, 1, "R3 still busy");
        wctrl(32'h0000_000D, 0);
        chk(xfer_req, 1, "R3 resumed");
        done_n(2);
        chk(busy, 1, "R3 count held");
        done_n(1);
        chk(busy, 0, "R3 finished");
        wctrl(32'h0000_010C, 0);

        // R2 triggers while disabled
        cur_req = "R2";
        chain_in = 1; cyc();
        chk(busy, 0, "R2 chain ignored");
        wtrig(32'h0000_0044);
        chk(busy, 0, "R2 trig ignored");
        wctrl(32'h0000_000C, 1);
        chk(busy, 0, "R2 ctrl trig ignored");

        // R5 zero count via chain input
        cur_req = "R5";
        wctrl(32'h0000_000D, 0);
        count_in = 0;
        chain_in = 1; cyc();
        chk(busy, 0, "R5 no busy"); chk(chain_out, 1, "R5 completion");
        chk(irq, 1, "R5 irq");
        wctrl(32'h0000_010D, 0);

        // R6 chain to self
        cur_req = "R6";
        wctrl(32'h0000_0021, 0);          // en=1, chain=8
        count_in = 1;
        wtrig(32'h0000_0001);
        done_n(1);
        chk(chain_out, 0, "R6 self no pulse"); chk(irq, 1, "R8 irq self");
        wctrl(32'h0000_0121, 0);

        // R9 quiet mode
        cur_req = "R9";
        wctrl(32'h0000_0023, 0);
        count_in = 2;
        wtrig(32'h0000_0001);
        done_n(2);
        chk(busy, 0, "R9 done"); chk(irq, 0, "R9 quiet no irq");
        wtrig(32'h0);
        chk(irq, 1, "R9 null irq"); chk(busy, 0, "R10 null no start");
        wctrl(32'h0000_0121, 0);

        // R10 null write with quiet off
        cur_req = "R10";
        wtrig(32'h0);
        chk(irq, 0, "R10 irq unchanged"); chk(busy, 0, "R10 no start");

        // R11 sticky errors
        cur_req = "R11";
        rd_err_in = 1; cyc();
        cyc();
        chk(rd_err, 1, "R11 rd sticky");
        rd_err_in = 1; wctrl(32'h0000_0061, 0);
        chk(rd_err, 1, "R11 rd set wins");
        wctrl(32'h0000_0061, 0);
        chk(rd_err, 0, "R11 rd cleared");
        wr_err_in = 1; cyc();
        wctrl(32'h0000_0061, 0);
        chk(wr_err, 1, "R11 wr not cleared by bit 6");
        wctrl(32'h0000_00A1, 0);
        chk(wr_err, 0, "R11 wr cleared");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule